// File: doc/BRIEF.md
# Store Commit Queue with Miss Bypass

This block holds stores that have executed but may not yet touch the data cache. A store is written into the queue once its address is known; it stays there as a finished store until the pipeline reports that the instruction completed, at which point it becomes a completed store. Completed stores then try to write the cache in program order, using only cycles in which the execute stage leaves the cache port free.

A store that hits is written and, once every older store has also been written, its entry is freed. A store that misses raises a line reload request and waits. Younger completed stores go on writing the cache past it, and further misses start further reloads. A reload-done input carrying a line address releases every waiting store on that line. Released stores retry the cache ahead of any new completed store. A flush throws away all finished stores that have not completed and leaves completed ones untouched.

Four pointers separate the regions of the circular buffer: the tail (next free slot), the finish boundary (oldest finished store), the completion boundary (next completed store to try the cache) and the commit boundary (oldest store not yet freed).

Top module: `sq_store_queue`

## Requirements
- R1: After reset the queue is empty: `enq_ready_o` is 1, and `cache_wr_o` and `reload_req_o` are 0.
- R2: A store that has been enqueued but not completed never drives a cache write, even when `cache_free_i` is 1.
- R3: Completed stores that hit write the cache in program order. Each write carries the address, data and byte enables given at enqueue.
- R4: The queue holds DEPTH (default 6) stores. `enq_ready_o` is 0 when all entries are occupied, and an enqueue offered while it is 0 is dropped.
- R5: `cache_wr_o` is asserted only in cycles where `cache_free_i` is 1.
- R6: A write attempt with `cache_hit_i` = 0 asserts `reload_req_o` in the same cycle, with `reload_line_o` = address bits [AW-1:LINE_W]. The store then waits, and younger completed stores keep writing the cache.
- R7: `reload_done_i` with a matching line makes each waiting store on that line retry the cache. A retry wins the port over a newly completed store.
- R8: Entries are freed only in order. A written store stays occupied while any older store is still waiting on a reload.
- R9: `flush_i` discards every finished store that has not completed, and such a store never writes the cache. A store that completes in the same cycle survives, and so do all earlier completed stores.
- R10: Several misses may be outstanding at once, each producing its own reload request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enq_valid_i | input | 1 | Executed store to insert |
| enq_addr_i | input | AW | Store physical address |
| enq_data_i | input | DW | Store data |
| enq_be_i | input | DW/8 | Byte enables |
| enq_ready_o | output | 1 | A free entry is available |
| complete_i | input | 1 | Oldest finished store has completed |
| flush_i | input | 1 | Discard finished, uncompleted stores |
| cache_free_i | input | 1 | Execute stage is not using the cache port |
| cache_wr_o | output | 1 | Cache write attempt |
| cache_addr_o | output | AW | Write address |
| cache_data_o | output | DW | Write data |
| cache_be_o | output | DW/8 | Write byte enables |
| cache_hit_i | input | 1 | Same-cycle hit response to the attempt |
| reload_req_o | output | 1 | Line reload request (on a miss) |
| reload_line_o | output | AW-LINE_W | Line address to reload |
| reload_done_i | input | 1 | A line reload has finished |
| reload_done_line_i | input | AW-LINE_W | Line address of the finished reload |

## Verification
On every cycle, the assertions check the following. The port is used only when the cache is free. Any write attempt is made by a completed or released entry. A full indication implies no free entry. A flush leaves no finished entry behind. A released store wins the port. A waiting store stays waiting until a reload finishes. The bench scenarios are needed to show the rest: program-order data on the write port, bypass past misses, retry order after a reload, in-order freeing seen through `enq_ready_o`, and the exact set of stores that survive a flush.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [2:0] {
    SQ_FREE  = 3'd0,
    SQ_FIN   = 3'd1,
    SQ_CMP   = 3'd2,
    SQ_MISS  = 3'd3,
    SQ_RETRY = 3'd4,
    SQ_WR    = 3'd5
  } sq_state_e;
endpackage

// File: rtl/sq_age_pick.sv
// Oldest request found by scanning from a start index with wrap
module sq_age_pick #(
  parameter int N  = 6,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] start_i,
  output logic          any_o,
  output logic [PW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      int j;
      j = int'(start_i) + i;
      if (j >= N) j = j - N;
      if (req_i[j]) begin
        any_o = 1'b1;
        idx_o = PW'(j);
      end
    end
  end
endmodule

// File: rtl/sq_entry.sv
module sq_entry
  import sq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int LINE_W = 5,
  localparam int BEW   = DW / 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       data_i,
  input  logic [BEW-1:0]      be_i,
  input  logic                cpl_i,
  input  logic                flush_i,
  input  logic                issue_i,
  input  logic                hit_i,
  input  logic                reload_done_i,
  input  logic [AW-LINE_W-1:0] reload_line_i,
  input  logic                retire_i,
  output sq_state_e           st_o,
  output logic [AW-1:0]       addr_o,
  output logic [DW-1:0]       data_o,
  output logic [BEW-1:0]      be_o
);
  sq_state_e st_q;
  logic      line_match;

  assign line_match = reload_done_i && (addr_o[AW-1:LINE_W] == reload_line_i);
  assign st_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_FREE;
    end else begin
      unique case (st_q)
        SQ_FREE:  if (alloc_i) st_q <= SQ_FIN;
        SQ_FIN:   if (cpl_i) st_q <= SQ_CMP;
                  else if (flush_i) st_q <= SQ_FREE;
        SQ_CMP, SQ_RETRY:
                  if (issue_i) st_q <= hit_i ? SQ_WR : (line_match ? SQ_RETRY : SQ_MISS);
        SQ_MISS:  if (line_match) st_q <= SQ_RETRY;
        SQ_WR:    if (retire_i) st_q <= SQ_FREE;
        default:  st_q <= SQ_FREE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
      be_o   <= be_i;
    end
  end
endmodule

// File: rtl/sq_store_queue.sv
module sq_store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int LINE_W = 5,
  localparam int BEW   = DW / 8,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enq_valid_i,
  input  logic [AW-1:0]        enq_addr_i,
  input  logic [DW-1:0]        enq_data_i,
  input  logic [BEW-1:0]       enq_be_i,
  output logic                 enq_ready_o,
  input  logic                 complete_i,
  input  logic                 flush_i,
  input  logic                 cache_free_i,
  output logic                 cache_wr_o,
  output logic [AW-1:0]        cache_addr_o,
  output logic [DW-1:0]        cache_data_o,
  output logic [BEW-1:0]       cache_be_o,
  input  logic                 cache_hit_i,
  output logic                 reload_req_o,
  output logic [AW-LINE_W-1:0] reload_line_o,
  input  logic                 reload_done_i,
  input  logic [AW-LINE_W-1:0] reload_done_line_i
);
  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [PW-1:0] tail_q, fin_q, cmp_q, com_q;
  sq_state_e     ent_st [DEPTH];
  logic [AW-1:0] ent_addr [DEPTH];
  logic [DW-1:0] ent_data [DEPTH];
  logic [BEW-1:0] ent_be [DEPTH];
  logic [DEPTH-1:0] retry_mask;
  logic          retry_any;
  logic [PW-1:0] retry_idx, issue_idx;
  logic          enq_acc, cpl_acc, has_cmp, issue, retire;

  assign enq_ready_o = (ent_st[tail_q] == SQ_FREE);
  assign enq_acc     = enq_valid_i && enq_ready_o && !flush_i;
  assign cpl_acc     = complete_i && (ent_st[fin_q] == SQ_FIN);
  assign has_cmp     = (ent_st[cmp_q] == SQ_CMP);
  assign retire      = (ent_st[com_q] == SQ_WR);

  for (genvar g = 0; g < DEPTH; g++) begin : g_mask
    assign retry_mask[g] = (ent_st[g] == SQ_RETRY);
  end

  sq_age_pick #(.N(DEPTH)) u_pick (
    .req_i   (retry_mask),
    .start_i (com_q),
    .any_o   (retry_any),
    .idx_o   (retry_idx)
  );

  // released stores win the port over fresh completed stores
  assign issue     = cache_free_i && (retry_any || has_cmp);
  assign issue_idx = retry_any ? retry_idx : cmp_q;

  assign cache_wr_o    = issue;
  assign cache_addr_o  = ent_addr[issue_idx];
  assign cache_data_o  = ent_data[issue_idx];
  assign cache_be_o    = ent_be[issue_idx];
  assign reload_req_o  = issue && !cache_hit_i;
  assign reload_line_o = cache_addr_o[AW-1:LINE_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    sq_entry #(.AW(AW), .DW(DW), .LINE_W(LINE_W)) u_ent (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .alloc_i       (enq_acc && (tail_q == PW'(g))),
      .addr_i        (enq_addr_i),
      .data_i        (enq_data_i),
      .be_i          (enq_be_i),
      .cpl_i         (cpl_acc && (fin_q == PW'(g))),
      .flush_i       (flush_i),
      .issue_i       (issue && (issue_idx == PW'(g))),
      .hit_i         (cache_hit_i),
      .reload_done_i (reload_done_i),
      .reload_line_i (reload_done_line_i),
      .retire_i      (retire && (com_q == PW'(g))),
      .st_o          (ent_st[g]),
      .addr_o        (ent_addr[g]),
      .data_o        (ent_data[g]),
      .be_o          (ent_be[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
      fin_q  <= '0;
      cmp_q  <= '0;
      com_q  <= '0;
    end else begin
      if (flush_i)      tail_q <= cpl_acc ? wrap_inc(fin_q) : fin_q;
      else if (enq_acc) tail_q <= wrap_inc(tail_q);
      if (cpl_acc)      fin_q  <= wrap_inc(fin_q);
      if (issue && !retry_any) cmp_q <= wrap_inc(cmp_q);
      if (retire)       com_q  <= wrap_inc(com_q);
    end
  end
endmodule

// File: rtl/sq_store_queue_chk.sv
module sq_store_queue_chk
  import sq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cache_free_i,
  input logic          cache_wr_o,
  input logic          enq_ready_o,
  input logic          flush_i,
  input logic          reload_done_i,
  input sq_state_e     ent_st [DEPTH],
  input logic          retry_any,
  input logic [PW-1:0] issue_idx
);
  logic [DEPTH-1:0] free_m, fin_m;
  for (genvar g = 0; g < DEPTH; g++) begin : g_m
    assign free_m[g] = (ent_st[g] == SQ_FREE);
    assign fin_m[g]  = (ent_st[g] == SQ_FIN);
  end

  p_wr_needs_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_wr_o |-> cache_free_i);

  p_wr_only_completed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_wr_o |-> (ent_st[issue_idx] == SQ_CMP || ent_st[issue_idx] == SQ_RETRY));

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enq_ready_o |-> (free_m == '0));

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (fin_m == '0));

  p_retry_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_wr_o && retry_any) |-> (ent_st[issue_idx] == SQ_RETRY));

  for (genvar g = 0; g < DEPTH; g++) begin : g_miss
    p_miss_waits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ent_st[g] == SQ_MISS && !reload_done_i) |=> (ent_st[g] == SQ_MISS));
  end
endmodule

bind sq_store_queue sq_store_queue_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sq_store_queue_tb_top.sv
module sq_store_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 64, LW = 5, BEW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 0, complete = 0, flush = 0, cache_free = 1, reload_done = 0;
  logic [AW-1:0] enq_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic [BEW-1:0] enq_be = '0;
  logic [AW-LW-1:0] done_line = '0;
  logic enq_ready, cache_wr, cache_hit, reload_req;
  logic [AW-1:0] cache_addr;
  logic [DW-1:0] cache_data;
  logic [BEW-1:0] cache_be;
  logic [AW-LW-1:0] reload_line;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sq_store_queue dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_addr_i(enq_addr), .enq_data_i(enq_data), .enq_be_i(enq_be),
    .enq_ready_o(enq_ready), .complete_i(complete), .flush_i(flush), .cache_free_i(cache_free),
    .cache_wr_o(cache_wr), .cache_addr_o(cache_addr), .cache_data_o(cache_data), .cache_be_o(cache_be),
    .cache_hit_i(cache_hit), .reload_req_o(reload_req), .reload_line_o(reload_line),
    .reload_done_i(reload_done), .reload_done_line_i(done_line)
  );

  // cache model: two lines can be marked missing
  localparam logic [AW-1:0] ADDR_A = 32'h0000_1008, ADDR_B = 32'h0000_2044;
  logic miss_a = 0, miss_b = 0;
  always_comb
    cache_hit = !((miss_a && cache_addr[AW-1:LW] == ADDR_A[AW-1:LW]) ||
                  (miss_b && cache_addr[AW-1:LW] == ADDR_B[AW-1:LW]));

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [BEW-1:0] b;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  int checks = 0, failures = 0, wr_cnt = 0, miss_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [BEW-1:0] b, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.b = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares successful writes against scoreboard, checks misses
  always @(negedge clk) begin
    if (rst_n && cache_wr) begin
      if (cache_hit) begin
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R3", "unexpected write addr", cache_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cache_addr == e.a, e.tag, "write addr", cache_addr, e.a);
          chk(cache_data == e.d, e.tag, "write data", cache_data, e.d);
          chk(cache_be == e.b, e.tag, "write be", cache_be, e.b);
        end
      end else begin
        miss_cnt++;
        chk(reload_req && reload_line == cache_addr[AW-1:LW], "R6", "reload on miss",
            {reload_req, reload_line}, {1'b1, cache_addr[AW-1:LW]});
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enq(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BEW-1:0] b);
    @(posedge clk); #1;
    enq_valid = 1; enq_addr = a; enq_data = d; enq_be = b;
    @(posedge clk); #1;
    enq_valid = 0;
  endtask

  task automatic cpl();
    @(posedge clk); #1; complete = 1;
    @(posedge clk); #1; complete = 0;
  endtask

  task automatic rdone(input logic [AW-1:0] a);
    @(posedge clk); #1; reload_done = 1; done_line = a[AW-1:LW];
    @(posedge clk); #1; reload_done = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk(enq_ready == 1, "R1", "enq_ready", enq_ready, 1);
    chk(cache_wr == 0 && reload_req == 0, "R1", "idle port", {cache_wr, reload_req}, 0);

    // R2 finished stores stay out of the cache
    enq(32'h100, 64'h11, 8'h0F);
    enq(32'h108, 64'h22, 8'hF0);
    enq(32'h110, 64'h33, 8'hFF);
    step(4);
    chk(wr_cnt == 0, "R2", "writes before completion", wr_cnt, 0);
    // R3 in-order writes with stored fields
    push(32'h100, 64'h11, 8'h0F, "R3");
    push(32'h108, 64'h22, 8'hF0, "R3");
    push(32'h110, 64'h33, 8'hFF, "R3");
    cpl(); cpl(); cpl();
    step(4);
    chk(wr_cnt == 3, "R3", "write count", wr_cnt, 3);

    // R5 no writes while port busy
    cache_free = 0;
    enq(32'h200, 64'h44, 8'h01);
    push(32'h200, 64'h44, 8'h01, "R5");
    cpl();
    step(4);
    chk(wr_cnt == 3, "R5", "write while busy", wr_cnt, 3);
    cache_free = 1;
    step(3);
    chk(wr_cnt == 4, "R5", "write after free", wr_cnt, 4);

    // R4 capacity
    for (int i = 0; i < 6; i++) enq(32'h300 + 32'(i * 8), 64'(i + 100), 8'h3C);
    chk(enq_ready == 0, "R4", "ready when full", enq_ready, 0);
    enq(32'h3F8, 64'hDEAD, 8'hFF);  // dropped
    for (int i = 0; i < 6; i++) push(32'h300 + 32'(i * 8), 64'(i + 100), 8'h3C, "R4");
    for (int i = 0; i < 6; i++) cpl();
    step(6);
    chk(wr_cnt == 10, "R4", "writes after drain", wr_cnt, 10);
    chk(enq_ready == 1, "R4", "ready after drain", enq_ready, 1);

    // R9 flush drops uncompleted stores only
    enq(32'h400, 64'h55, 8'h11);
    enq(32'h408, 64'h66, 8'h22);
    enq(32'h410, 64'h77, 8'h33);
    push(32'h400, 64'h55, 8'h11, "R9");
    cpl();
    @(posedge clk); #1; flush = 1; complete = 1;  // second completes with flush
    push(32'h408, 64'h66, 8'h22, "R9");
    @(posedge clk); #1; flush = 0; complete = 0;
    step(4);
    chk(wr_cnt == 12, "R9", "writes after flush", wr_cnt, 12);
    enq(32'h418, 64'h88, 8'h44);
    push(32'h418, 64'h88, 8'h44, "R9");
    cpl();
    step(4);
    chk(wr_cnt == 13, "R9", "post-flush store", wr_cnt, 13);

    // R6 R10 bypass past two misses
    miss_a = 1; miss_b = 1;
    enq(ADDR_A, 64'hA0, 8'h01);
    enq(ADDR_B, 64'hB0, 8'h02);
    enq(32'h500, 64'hC0, 8'h04);
    enq(32'h508, 64'hD0, 8'h08);
    push(32'h500, 64'hC0, 8'h04, "R6");
    push(32'h508, 64'hD0, 8'h08, "R6");
    for (int i = 0; i < 4; i++) cpl();
    step(4);
    chk(wr_cnt == 15, "R6", "bypass writes", wr_cnt, 15);
    chk(miss_cnt == 2, "R10", "outstanding misses", miss_cnt, 2);
    chk(exp_q.size() == 0, "R6", "bypass drained", exp_q.size(), 0);

    // R8 written stores held behind the miss
    enq(32'h600, 64'hE0, 8'h10);
    enq(32'h608, 64'hF0, 8'h20);
    step(2);
    chk(enq_ready == 0, "R8", "occupied behind miss", enq_ready, 0);

    // R7 retry wins over a fresh completed store
    cache_free = 0;
    cpl();
    miss_a = 0;
    push(ADDR_A, 64'hA0, 8'h01, "R7");
    push(32'h600, 64'hE0, 8'h10, "R7");
    rdone(ADDR_A);
    cache_free = 1;
    step(4);
    chk(wr_cnt == 17, "R7", "retry writes", wr_cnt, 17);
    miss_b = 0;
    push(ADDR_B, 64'hB0, 8'h02, "R7");
    rdone(ADDR_B);
    push(32'h608, 64'hF0, 8'h20, "R3");
    cpl();
    step(6);
    w = wr_cnt;
    chk(w == 19, "R7", "all written", w, 19);
    chk(miss_cnt == 2, "R10", "no extra reload", miss_cnt, 2);
    chk(exp_q.size() == 0, "R3", "scoreboard empty", exp_q.size(), 0);
    chk(enq_ready == 1, "R8", "freed after drain", enq_ready, 1);
    summary();
  end
endmodule